// File: doc/BRIEF.md
# Split-Read Wide Counter Reconstructor

This block keeps a free-running tick counter twice as wide as its read path and turns three separate half-word reads of it into one coherent timestamp. The counter advances on every clock cycle in which the tick enable is high. Only one half of it can be seen per cycle, through a single half-width read path. A read request starts a sampling sequence. The sequence takes the upper half, then the lower half, then the upper half again. Consecutive samples are separated by a fixed number of idle cycles set by a parameter.

Once the third sample is in, a rollover rule decides which upper sample belongs with the lower sample. When the two upper samples agree, either one is used. When they disagree, the most significant bit of the lower sample shows on which side of the lower read the carry happened. A clear bit means the carry came before the lower read, so the second upper sample is used. A set bit means the carry came after it, so the first upper sample is used. The rebuilt value is therefore the counter value at the instant the lower half was taken. This holds provided the counter advances by less than half the lower range during the sequence. By default the counter is 32 bits wide and the read path is 16 bits wide.

Top module: `split_read_timestamp`

## Requirements
- R1: The counter increases by exactly one on each rising clock edge where `tick_en` is high, and holds its value otherwise.
- R2: The counter wraps from all ones to zero. Synchronous reset clears the counter and drives `busy`, `valid` and `result` low.
- R3: A `rd_req` sampled high while `busy` is low is accepted, and `busy` is high from the next cycle on.
- R4: After acceptance, samples are taken at the 1st, (READ_GAP+2)th and (2*READ_GAP+3)th clock edges. In that order they take the upper half, the lower half and the upper half. At most one sample is taken per cycle.
- R5: `valid` goes high for exactly one cycle after the third sample edge, and `busy` falls at that same edge. `result` holds its value until the next completed sequence.
- R6: If both upper samples are equal, `result` is the first upper sample concatenated with the lower sample.
- R7: If the upper samples differ and bit HALF_W-1 of the lower sample is 0, the upper half of `result` is the second upper sample.
- R8: If the upper samples differ and bit HALF_W-1 of the lower sample is 1, the upper half of `result` is the first upper sample.
- R9: A `rd_req` that arrives while `busy` is high has no effect: it neither restarts the sequence nor causes a second `valid` pulse.
- R10: When the counter advances fewer than 2^(HALF_W-1)-1 times between the first and the third sample, `result` equals the counter value seen at the lower-half sample edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Advance the counter by one at this edge |
| rd_req | input | 1 | Start a sampling sequence (ignored while busy) |
| busy | output | 1 | Sampling sequence in progress |
| valid | output | 1 | One-cycle pulse: `result` is new |
| result | output | 2*HALF_W | Rebuilt counter value |

## Verification
With the request accepted at edge 0, `busy` is due one cycle later. The lower-half sample is taken at edge READ_GAP+2. `valid` and the new `result` are due right after edge 2*READ_GAP+3. The bench sets inputs on falling edges, counts falling edges from the request, and reads outputs only in those exact slots. It also records its own counter model at the lower-sample slot and uses that value as the expected result. Tick-enable pulses are placed at chosen edge indices so that a carry into the upper half falls before or after the lower read, including the full wrap to zero. A second configuration with a 4-bit read path keeps those events within a few hundred cycles.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // Which of the three reads the sequencer is waiting to take
  typedef enum logic [1:0] {
    PH_HI1 = 2'd0,
    PH_LO  = 2'd1,
    PH_HI2 = 2'd2
  } phase_t;

endpackage

// File: rtl/tsr_tick_counter.sv
module tsr_tick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;

  // natural modulo-2^CNT_W wrap from all ones to zero
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (tick_en) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;

endmodule

// File: rtl/tsr_half_port.sv
module tsr_half_port #(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] count,
  input  logic                sel_upper,
  output logic [HALF_W-1:0]   half
);

  // one narrow read path: each bit picks from its upper or lower twin
  for (genvar b = 0; b < HALF_W; b++) begin : g_lane
    assign half[b] = sel_upper ? count[HALF_W + b] : count[b];
  end

endmodule

// File: rtl/tsr_sample_seq.sv
module tsr_sample_seq
  import tsr_pkg::*;
#(
  parameter int HALF_W   = 16,
  parameter int READ_GAP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [HALF_W-1:0] half_in,
  output logic              sel_upper,
  output logic              busy,
  output logic              valid,
  output logic              ev_hi1,
  output logic              ev_lo,
  output logic              ev_hi2,
  output logic [HALF_W-1:0] hi1_q,
  output logic [HALF_W-1:0] lo_q
);

  localparam int GW = (READ_GAP > 0) ? $clog2(READ_GAP + 1) : 1;
  localparam logic [GW-1:0] GAP_V = GW'(READ_GAP);

  phase_t      phase_q;
  logic [GW-1:0] gap_q;
  logic        busy_q;
  logic        valid_q;
  logic        take;

  assign take      = busy_q && (gap_q == '0);
  assign ev_hi1    = take && (phase_q == PH_HI1);
  assign ev_lo     = take && (phase_q == PH_LO);
  assign ev_hi2    = take && (phase_q == PH_HI2);
  assign sel_upper = (phase_q != PH_LO);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_HI1;
      gap_q   <= '0;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      hi1_q   <= '0;
      lo_q    <= '0;
    end else begin
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (rd_req) begin
          busy_q  <= 1'b1;
          phase_q <= PH_HI1;
          gap_q   <= '0;
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
      end else begin
        unique case (phase_q)
          PH_HI1: begin
            hi1_q   <= half_in;
            phase_q <= PH_LO;
            gap_q   <= GAP_V;
          end
          PH_LO: begin
            lo_q    <= half_in;
            phase_q <= PH_HI2;
            gap_q   <= GAP_V;
          end
          default: begin
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
            phase_q <= PH_HI1;
          end
        endcase
      end
    end
  end

  assign busy  = busy_q;
  assign valid = valid_q;

endmodule

// File: rtl/tsr_rollover_pick.sv
module tsr_rollover_pick #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0] hi_first,
  input  logic [HALF_W-1:0] lo_mid,
  input  logic [HALF_W-1:0] hi_second,
  output logic [HALF_W-1:0] hi_pick
);

  // Lower MSB set: lower read came before the carry, so the early upper fits.
  // Lower MSB clear: carry already happened, so the late upper fits.
  function automatic logic [HALF_W-1:0] choose_upper(
    input logic [HALF_W-1:0] a,
    input logic [HALF_W-1:0] lo,
    input logic [HALF_W-1:0] b
  );
    if (a == b)             return a;
    else if (lo[HALF_W-1])  return a;
    else                    return b;
  endfunction

  assign hi_pick = choose_upper(hi_first, lo_mid, hi_second);

endmodule

// File: rtl/split_read_timestamp.sv
module split_read_timestamp #(
  parameter int HALF_W   = 16,
  parameter int READ_GAP = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick_en,
  input  logic                rd_req,
  output logic                busy,
  output logic                valid,
  output logic [2*HALF_W-1:0] result
);

  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [HALF_W-1:0] half_rd;
  logic              sel_upper;
  logic              ev_hi1, ev_lo, ev_hi2;
  logic [HALF_W-1:0] hi1_q, lo_q, hi_pick;
  logic [CNT_W-1:0]  result_q;

  tsr_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .count   (cnt_q)
  );

  tsr_half_port #(.HALF_W(HALF_W)) u_port (
    .count     (cnt_q),
    .sel_upper (sel_upper),
    .half      (half_rd)
  );

  tsr_sample_seq #(.HALF_W(HALF_W), .READ_GAP(READ_GAP)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .half_in   (half_rd),
    .sel_upper (sel_upper),
    .busy      (busy),
    .valid     (valid),
    .ev_hi1    (ev_hi1),
    .ev_lo     (ev_lo),
    .ev_hi2    (ev_hi2),
    .hi1_q     (hi1_q),
    .lo_q      (lo_q)
  );

  // the second upper sample is the live read-path value at the last edge
  tsr_rollover_pick #(.HALF_W(HALF_W)) u_pick (
    .hi_first  (hi1_q),
    .lo_mid    (lo_q),
    .hi_second (half_rd),
    .hi_pick   (hi_pick)
  );

  always_ff @(posedge clk) begin
    if (rst)         result_q <= '0;
    else if (ev_hi2) result_q <= {hi_pick, lo_q};
  end

  assign result = result_q;

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                tick_en,
  input logic                rd_req,
  input logic                busy,
  input logic                valid,
  input logic [2*HALF_W-1:0] result,
  input logic [2*HALF_W-1:0] cnt_q,
  input logic                ev_hi1,
  input logic                ev_lo,
  input logic                ev_hi2,
  input logic [HALF_W-1:0]   hi1_q,
  input logic [HALF_W-1:0]   lo_q
);

  localparam int CNT_W = 2 * HALF_W;

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(cnt_q));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_en && (&cnt_q)) |=> (cnt_q == '0));

  // R2
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cnt_q == '0 && !busy && !valid));

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !busy) |=> busy);

  // R4
  sample_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_hi1, ev_lo, ev_hi2}));

  // R4
  sample_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_hi1 || ev_lo || ev_hi2) |-> busy);

  // R5
  hi2_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ev_hi2 |=> (valid && !busy));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R5
  valid_low_half_chk: assert property (@(posedge clk) disable iff (rst)
    valid |-> (result[HALF_W-1:0] == lo_q));

  // R6
  match_pick_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_hi2 && (hi1_q == cnt_q[CNT_W-1:HALF_W]))
      |=> (result[CNT_W-1:HALF_W] == $past(hi1_q)));

  // R9
  ignore_req_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_req && !ev_hi2) |=> (busy && !valid));

endmodule

bind split_read_timestamp tsr_checker #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .rd_req  (rd_req),
  .busy    (busy),
  .valid   (valid),
  .result  (result),
  .cnt_q   (cnt_q),
  .ev_hi1  (ev_hi1),
  .ev_lo   (ev_lo),
  .ev_hi2  (ev_hi2),
  .hi1_q   (hi1_q),
  .lo_q    (lo_q)
);

// File: tb/sim_split_read_timestamp.sv
module sim_split_read_timestamp;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;   // 125 MHz

  // wide instance (default widths, gap 2)
  logic        tk0 = 1'b0, rq0 = 1'b0, by0, vl0;
  logic [31:0] rs0;
  // narrow instance (4-bit read path, gap 1) for carry and wrap cases
  logic        tk1 = 1'b0, rq1 = 1'b0, by1, vl1;
  logic [7:0]  rs1;

  split_read_timestamp u0 (
    .clk(clk), .rst(rst), .tick_en(tk0), .rd_req(rq0),
    .busy(by0), .valid(vl0), .result(rs0)
  );

  split_read_timestamp #(.HALF_W(4), .READ_GAP(1)) u1 (
    .clk(clk), .rst(rst), .tick_en(tk1), .rd_req(rq1),
    .busy(by1), .valid(vl1), .result(rs1)
  );

  // reference tick counters built from the requirement text
  logic [31:0] m0 = '0;
  logic [7:0]  m1 = '0;
  always @(posedge clk) begin
    if (rst) begin m0 <= '0; m1 <= '0; end
    else begin
      if (tk0) m0 <= m0 + 32'd1;
      if (tk1) m1 <= m1 + 8'd1;
    end
  end

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl(input bit inst);
    return inst ? {24'd0, m1} : m0;
  endfunction
  function automatic logic busy_of(input bit inst);
    return inst ? by1 : by0;
  endfunction
  function automatic logic valid_of(input bit inst);
    return inst ? vl1 : vl0;
  endfunction
  function automatic logic [31:0] res_of(input bit inst);
    return inst ? {24'd0, rs1} : rs0;
  endfunction

  task automatic set_in(input bit inst, input logic rq, input logic tk);
    if (inst) begin rq1 = rq; tk1 = tk; end
    else      begin rq0 = rq; tk0 = tk; end
  endtask

  // tick for n edges, called at a falling edge, returns at a falling edge
  task automatic advance(input bit inst, input int n);
    if (n > 0) begin
      set_in(inst, 1'b0, 1'b1);
      repeat (n) @(negedge clk);
      set_in(inst, 1'b0, 1'b0);
    end
  endtask

  // one read; ticks are driven at falling-edge indices tk_a..tk_b
  task automatic do_read(input bit inst, input int tk_a, input int tk_b,
                         input bit extra_req, input string tag);
    int gap;
    int lo_at;
    int vcyc;
    logic [31:0] exp_v;
    gap   = inst ? 1 : 2;
    lo_at = gap + 2;
    vcyc  = 2 * gap + 4;
    exp_v = '0;
    chk("R3 idle before request", {31'd0, busy_of(inst)}, 32'd0);
    set_in(inst, 1'b1, (tk_a <= 0) && (tk_b >= 0));
    for (int j = 1; j <= vcyc + 1; j++) begin
      @(negedge clk);
      set_in(inst, extra_req && (j == 3), (j >= tk_a) && (j <= tk_b) && (j < vcyc));
      if (j == 1) chk("R3 busy after accept", {31'd0, busy_of(inst)}, 32'd1);
      if (j == lo_at) exp_v = mdl(inst);
      if (j == vcyc - 1)
        chk("R5 no early valid", {30'd0, busy_of(inst), valid_of(inst)}, 32'd2);
      if (j == vcyc) begin
        chk("R5 valid with busy low", {30'd0, busy_of(inst), valid_of(inst)}, 32'd1);
        chk(tag, res_of(inst), exp_v);
      end
      if (j == vcyc + 1) begin
        chk("R5 single pulse", {31'd0, valid_of(inst)}, 32'd0);
        chk("R5 result held", res_of(inst), exp_v);
      end
    end
    set_in(inst, 1'b0, 1'b0);
    if (extra_req) begin
      logic seen;
      seen = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (valid_of(inst) || busy_of(inst)) seen = 1'b1;
      end
      chk("R9 request while busy ignored", {31'd0, seen}, 32'd0);
    end
  endtask

  task automatic t_reset;
    chk("R2 reset busy/valid", {28'd0, by0, vl0, by1, vl1}, 32'd0);
    chk("R2 reset result wide", rs0, 32'd0);
    chk("R2 reset result narrow", {24'd0, rs1}, 32'd0);
    do_read(1'b0, -1, -1, 1'b0, "R2 counter cleared by reset");
  endtask

  task automatic t_wide_basic;
    advance(1'b0, 1000);
    do_read(1'b0, -1, -1, 1'b0, "R4/R6 idle counter read");
    do_read(1'b0, -1, -1, 1'b0, "R1 hold without tick");
    do_read(1'b0, 0, 99, 1'b0, "R1/R10 ticking through the read");
  endtask

  task automatic t_wide_ignore;
    do_read(1'b0, -1, -1, 1'b1, "R9 result of the first request");
  endtask

  task automatic t_carry_before_lo;
    advance(1'b1, int'(8'h0F - m1));
    do_read(1'b1, 1, 1, 1'b0, "R7 carry between first upper and lower");
  endtask

  task automatic t_carry_after_lo;
    advance(1'b1, int'(8'h1F - m1));
    do_read(1'b1, 3, 3, 1'b0, "R8 carry between lower and second upper");
  endtask

  task automatic t_wrap;
    advance(1'b1, int'(8'hFF - m1));
    do_read(1'b1, 3, 3, 1'b0, "R8 full wrap after lower read");
    do_read(1'b1, -1, -1, 1'b0, "R2 wrapped to zero");
    advance(1'b1, int'(8'hFF - m1));
    do_read(1'b1, 2, 2, 1'b0, "R7 full wrap before lower read");
  endtask

  task automatic t_narrow_run;
    advance(1'b1, int'(8'h06 - m1));
    do_read(1'b1, 0, 99, 1'b0, "R10 continuous ticking across a carry");
    do_read(1'b1, 0, 99, 1'b0, "R10 continuous ticking second read");
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_wide_basic();
    t_wide_ignore();
    t_carry_before_lo();
    t_carry_after_lo();
    t_wrap();
    t_narrow_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule